// File: doc/BRIEF.md
# Multiplexed Segment Display Drive Sequencer

This block steps a segment liquid-crystal panel through its drive pattern. It drives up to four common lines and a parameterised number of segment lines. Every line gets a two-bit level code, and a downstream bias network turns that code into a voltage. The mode input selects one of four multiplex ratios: one, two, three or four commons. A second input selects how polarity is inverted. The first choice inverts inside every common's slot, so each frame is balanced by itself. The second choice inverts once per frame, so a balanced cycle spans two frames.

Each pulse of the tick input ends one slot. The pixel array is indexed by common and segment. While a common holds its slot, the segment codes follow that common's row of pixels. A sleep request is held off until the drive has just completed a balanced cycle. While the request is honoured, every line is parked at level 0. Changing the mode or the inversion style sends the sequence back to its first slot.

Top module: `lcd_wave_seq`

## Requirements
- R1: While reset is asserted, and until the first tick afterwards, the sequencer is at common 0 in positive phase and is not asleep. With mode 0 this gives com_lvl = 8'h03.
- R2: Level code n stands for bias level Vn (0 to 3). Mode values are 0 = static, 1 = two commons, 2 = three commons, 3 = four commons. In modes 1 to 3 during positive phase, the active common is at code 3 and the other used commons are at code 1. A segment whose pixel is on is at code 0, and one whose pixel is off is at code 2.
- R3: In modes 1 to 3 during negative phase, the active common is at code 0 and the other used commons are at code 2. An on segment is at code 3 and an off segment is at code 1.
- R4: In mode 0, common 0 is at code 3 in positive phase and at code 0 in negative phase. Each segment sits at the same code as common 0 when its pixel is off, and at the opposite extreme code when its pixel is on.
- R5: With wave_b = 0, each tick moves first from positive to negative phase within the same common. The next tick moves to the following common in positive phase, and the sequence wraps after the last used common.
- R6: With wave_b = 1, each tick moves to the next used common without changing phase. Phase flips only on the tick that wraps from the last common back to common 0.
- R7: A common whose index is above the mode value drives code 0.
- R8: bal_pt is high only while tick is high in the last slot of a balanced cycle. That slot is the last common in negative phase, which is the end of every frame with wave_b = 0 and the end of every second frame with wave_b = 1.
- R9: Sleep starts only on a clock edge where bal_pt and sleep_req are both high. While asleep, every com_lvl and seg_lvl code is 0 and ticks have no effect.
- R10: One edge after sleep_req goes low during sleep, asleep clears and drive resumes at common 0 in positive phase.
- R11: A change of mode or wave_b takes effect on the next clock edge and restarts the sequence at common 0 in positive phase. A restart takes priority over a tick in the same cycle.
- R12: The segment codes follow the active common's row of pix without delay. Pixel (c, s) is bit c*NSEG+s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse ending the current slot |
| mode | input | 2 | Multiplex ratio: 0 static, 1 two, 2 three, 3 four commons |
| wave_b | input | 1 | 0: invert inside each slot; 1: invert at frame boundaries |
| sleep_req | input | 1 | Request to park the drive |
| pix | input | 4*NSEG | Pixel array, bit c*NSEG+s for common c, segment s |
| com_lvl | output | 8 | Level code of common c at bits 2c+1:2c |
| seg_lvl | output | 2*NSEG | Level code of segment s at bits 2s+1:2s |
| bal_pt | output | 1 | High during the tick that closes a DC-balanced cycle |
| asleep | output | 1 | Drive parked at level 0 |

## Verification
The slot and phase registers move on the edge that samples a tick. The level codes decode those registers directly, so com_lvl and seg_lvl are settled one edge after the tick. A mode or inversion change also appears one edge later, because it passes through one register. The bench therefore drives its inputs on the falling edge and reads the results on the following falling edge. Two results have no delay at all: seg_lvl follows a new pix value immediately, and bal_pt follows tick immediately. Those two are read a short time after the input changes and before any rising edge. Entering and leaving sleep each take one edge and are checked on the next falling edge.

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq #(
  parameter int NSEG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              wave_b,
  input  logic              sleep_req,
  input  logic [4*NSEG-1:0] pix,
  output logic [7:0]        com_lvl,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic              bal_pt,
  output logic              asleep
);

  localparam int NCOM = 4;
  localparam int LW   = 2;

  logic [1:0]      mode_q, cur;
  logic            wb_q, ph;
  logic            restart, wrap;
  logic [NSEG-1:0] row;

  assign restart = (mode != mode_q) || (wave_b != wb_q);
  assign wrap    = (cur == mode_q);
  assign bal_pt  = tick && !asleep && !restart && ph && wrap;
  assign row     = pix[cur*NSEG +: NSEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      wb_q   <= 1'b0;
      cur    <= 2'd0;
      ph     <= 1'b0;
      asleep <= 1'b0;
    end else begin
      mode_q <= mode;
      wb_q   <= wave_b;
      if (restart) begin
        cur <= 2'd0;
        ph  <= 1'b0;
      end else if (asleep) begin
        if (!sleep_req) asleep <= 1'b0;
      end else if (tick) begin
        if (bal_pt && sleep_req) asleep <= 1'b1;
        if (!wb_q) begin
          ph <= ~ph;
          if (ph) cur <= wrap ? 2'd0 : cur + 2'd1;
        end else begin
          if (wrap) ph <= ~ph;
          cur <= wrap ? 2'd0 : cur + 2'd1;
        end
      end
    end
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    always_comb begin
      if (asleep || c > int'(mode_q))
        com_lvl[c*LW +: LW] = 2'd0;
      else if (c == int'(cur))
        com_lvl[c*LW +: LW] = ph ? 2'd0 : 2'd3;
      else
        com_lvl[c*LW +: LW] = ph ? 2'd2 : 2'd1;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_comb begin
      if (asleep)
        seg_lvl[s*LW +: LW] = 2'd0;
      else if (mode_q == 2'd0)
        seg_lvl[s*LW +: LW] = (row[s] ^ ph) ? 2'd0 : 2'd3;
      else if (!ph)
        seg_lvl[s*LW +: LW] = row[s] ? 2'd0 : 2'd2;
      else
        seg_lvl[s*LW +: LW] = row[s] ? 2'd3 : 2'd1;
    end
  end

  logic [NCOM-1:0] hi_com;
  always_comb
    for (int c = 0; c < NCOM; c++) hi_com[c] = (com_lvl[c*LW +: LW] == 2'd3);

  // R9
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(bal_pt && sleep_req));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (com_lvl == 8'd0 && seg_lvl == '0));

  // R11
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cur == 2'd0 && !ph));

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= mode_q);

  // R2
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !ph) |-> $countones(hi_com) == 1);

  // R8
  bal_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bal_pt |=> (asleep || (cur == 2'd0 && !ph) || restart));

endmodule

// File: tb/sim_lcd_wave_seq.sv
module sim_lcd_wave_seq;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wave_b = 1'b0, sleep_req = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [4*NS-1:0] pix = 32'hA53C_0F96;
  logic [7:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic bal_pt, asleep;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  lcd_wave_seq #(.NSEG(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .wave_b(wave_b),
    .sleep_req(sleep_req), .pix(pix), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .bal_pt(bal_pt), .asleep(asleep));

  // fields: mode(2) wave_b(1) ticks(4) common(2) phase(1)
  localparam logic [9:0] VEC [14] = '{
    {2'd1, 1'b0, 4'd0, 2'd0, 1'b0}, {2'd1, 1'b0, 4'd1, 2'd0, 1'b1},
    {2'd1, 1'b0, 4'd3, 2'd1, 1'b1}, {2'd1, 1'b0, 4'd4, 2'd0, 1'b0},
    {2'd3, 1'b0, 4'd5, 2'd2, 1'b1}, {2'd3, 1'b0, 4'd7, 2'd3, 1'b1},
    {2'd2, 1'b1, 4'd2, 2'd2, 1'b0}, {2'd2, 1'b1, 4'd3, 2'd0, 1'b1},
    {2'd2, 1'b1, 4'd5, 2'd2, 1'b1}, {2'd2, 1'b1, 4'd6, 2'd0, 1'b0},
    {2'd0, 1'b0, 4'd1, 2'd0, 1'b1}, {2'd0, 1'b1, 4'd1, 2'd0, 1'b1},
    {2'd0, 1'b1, 4'd2, 2'd0, 1'b0}, {2'd3, 1'b1, 4'd6, 2'd2, 1'b1}
  };

  function automatic logic [7:0] mk_com(int m, int c, bit p);
    logic [7:0] r;
    for (int i = 0; i < 4; i++)
      r[2*i +: 2] = (i > m) ? 2'd0 : (i == c) ? (p ? 2'd0 : 2'd3) : (p ? 2'd2 : 2'd1);
    return r;
  endfunction

  function automatic logic [2*NS-1:0] mk_seg(int m, int c, bit p, logic [4*NS-1:0] px);
    logic [2*NS-1:0] r;
    for (int s = 0; s < NS; s++) begin
      bit on = px[c*NS+s];
      if (m == 0) r[2*s +: 2] = (on == p) ? 2'd3 : 2'd0;
      else if (!p) r[2*s +: 2] = on ? 2'd0 : 2'd2;
      else r[2*s +: 2] = on ? 2'd3 : 2'd1;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_cfg(logic [1:0] m, logic wb);
    mode = m ^ 2'd1;
    wave_b = wb;
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R4 R7 reset state
    chk("R1", {asleep, bal_pt}, 2'b00);
    chk("R1", com_lvl, 8'h03);
    chk("R4", seg_lvl, mk_seg(0, 0, 0, pix));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", com_lvl, 8'h03);

    // R2 R3 R4 R5 R6 R7 vector walk
    foreach (VEC[i]) begin
      set_cfg(VEC[i][9:8], VEC[i][7]);
      for (int k = 0; k < int'(VEC[i][6:3]); k++) pulse();
      chk(VEC[i][7] ? "R6" : "R5", com_lvl,
          mk_com(VEC[i][9:8], VEC[i][2:1], VEC[i][0]));
      chk(VEC[i][0] ? "R3" : "R2", seg_lvl,
          mk_seg(VEC[i][9:8], VEC[i][2:1], VEC[i][0], pix));
    end

    // R12 pixel change seen without a clock edge
    set_cfg(2'd3, 1'b0);
    pulse(); pulse(); pulse();
    @(posedge clk);
    #2 pix = 32'h1234_5678;
    #1 chk("R12", seg_lvl, mk_seg(3, 1, 1, pix));
    @(negedge clk);

    // R11 change of wave_b mid-frame, with a tick in the same cycle
    wave_b = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R11", com_lvl, mk_com(3, 0, 0));

    // R8 end of first frame with wave_b=1 is not a balance point
    set_cfg(2'd2, 1'b1);
    pulse(); pulse();
    tick = 1'b1;
    #1 chk("R8", bal_pt, 1'b0);
    @(negedge clk);
    tick = 1'b0;

    // R8 R9 R10 sleep handshake
    set_cfg(2'd1, 1'b0);
    sleep_req = 1'b1;
    pulse();
    tick = 1'b1;
    #1 chk("R8", bal_pt, 1'b0);
    @(negedge clk);
    tick = 1'b0;
    chk("R9", asleep, 1'b0);
    pulse();
    tick = 1'b1;
    #1 chk("R8", bal_pt, 1'b1);
    @(negedge clk);
    tick = 1'b0;
    chk("R9", asleep, 1'b1);
    chk("R9", {com_lvl, seg_lvl}, '0);
    pulse();
    chk("R9", {asleep, com_lvl, seg_lvl}, {1'b1, 24'd0});
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R10", asleep, 1'b0);
    chk("R10", com_lvl, mk_com(1, 0, 0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule